// File: doc/BRIEF.md
# Burst DMA Write Engine

This block carries out the memory side of a remote write. A start pulse gives it a base address, a byte count and two packing options. It requests a shared memory/register bus and waits for a grant. On the first grant it acknowledges the start. It then issues one address/data/strobe write per bus word and advances the address by the bus width in bytes after each accepted word.

Bytes arrive on a valid/ready byte stream and are packed into bus words. The byte order within a word and the bit order within each byte are chosen per transfer. Words go out in bursts of a configured length. After each burst the engine drops its request for at least one cycle, so other masters can win the bus, and then asks again. When the byte count is not a multiple of the bus width, the last word carries byte enables only for the lanes that hold data.

When the final word has been accepted and the bus released, the engine emits a one-cycle done pulse. A watchdog counts cycles in which the engine waits on the bus, either for a grant or for acceptance of a write. If the count reaches its limit, the engine drops the request and ends with done and a timeout flag.

Top module: `dma_write_engine`

## Requirements
- R1: After reset, bus_req_o, bus_wr_o, fifo_ready_o, start_ack_o and done_o are all low.
- R2: A start with a non-zero count raises bus_req_o. start_ack_o pulses exactly once per transfer, in the cycle of the first grant.
- R3: Writes are issued only while the request is held and the grant is present. At most BURST_LEN words are accepted per grant, and bus_req_o goes low for at least one cycle between bursts, so a transfer of W words takes ceil(W/BURST_LEN) grants.
- R4: The first write goes to start_addr_i, and each accepted word (bus_wr_o and bus_ack_i high at a clock edge) advances the address by DATA_W/8.
- R5: With cfg_big_endian_i low, stream byte k of a word lands in lane k (bits 8k+7:8k). With it high, it lands in lane DATA_W/8-1-k.
- R6: With cfg_bit_rev_i high, each byte is bit-reversed before placement (stream bit 0 lands in bit 7 of its lane). With it low, the byte is unchanged.
- R7: bus_be_o has a bit set for exactly the lanes that hold stream bytes. Full words have all bits set, and in the final partial word the lanes without data are zero in both the enables and the data.
- R8: While bus_wr_o is high and bus_ack_i is low, the address, data and enables stay unchanged in the next cycle.
- R9: If WDOG_LIMIT consecutive cycles pass with a grant pending or a write not accepted, the engine drops bus_req_o and pulses done_o with timeout_o high.
- R10: A start with a byte count of zero produces done_o in the next cycle, with no bus request, no write and timeout_o low.
- R11: A successful transfer ends with a single-cycle done_o, timeout_o low and bus_req_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted while idle |
| start_addr_i | input | ADDR_W | Base byte address, word aligned |
| byte_count_i | input | CNT_W | Number of bytes to write |
| cfg_big_endian_i | input | 1 | Place first stream byte in the top lane |
| cfg_bit_rev_i | input | 1 | Reverse bit order of each byte |
| start_ack_o | output | 1 | Pulse on the first grant of a transfer |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| timeout_o | output | 1 | Valid with done_o; transfer aborted by watchdog |
| fifo_data_i | input | 8 | Stream byte |
| fifo_valid_i | input | 1 | Stream byte present |
| fifo_ready_o | output | 1 | Engine takes the byte at this edge |
| bus_req_o | output | 1 | Bus request |
| bus_gnt_i | input | 1 | Bus grant |
| bus_addr_o | output | ADDR_W | Write address |
| bus_wdata_o | output | DATA_W | Write data |
| bus_be_o | output | DATA_W/8 | Byte enables |
| bus_wr_o | output | 1 | Write strobe |
| bus_ack_i | input | 1 | Write accepted |

## Verification
The bench aims at counts that end one byte short of a word, on a word, on a burst boundary and one byte past it. An engine with a wrong final mask would write stale lanes, and one with a wrong burst counter would hold the bus for an extra word or take the wrong number of grants. Each transfer mixes random lane order and bit order with random grant latency and random acceptance stalls. This exposes swapped lanes, a flipped byte, an address that moves without acceptance, and data that changes during a stall. Directed runs withhold the grant, or grant and never accept, to catch a watchdog that never fires or fires at the wrong time. A zero-length start is also run, and an engine that touches the bus for it fails the check.

// File: rtl/dma_wr_pkg.sv
package dma_wr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_REQ  = 3'd1,
    ST_XFER = 3'd2,
    ST_REL  = 3'd3,
    ST_FIN  = 3'd4
  } dma_state_e;

  function automatic logic [7:0] flip_bits(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

endpackage

// File: rtl/dma_byte_packer.sv
module dma_byte_packer #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_i,
  input  logic [CNT_W-1:0]    count_i,
  input  logic                big_i,
  input  logic                rev_i,
  input  logic [7:0]          byte_i,
  input  logic                valid_i,
  output logic                ready_o,
  output logic [DATA_W-1:0]   word_o,
  output logic [DATA_W/8-1:0] be_o,
  output logic                word_valid_o,
  input  logic                consume_i
);
  import dma_wr_pkg::*;

  localparam int NB = DATA_W / 8;
  localparam int LW = $clog2(NB);

  logic [CNT_W-1:0]  left_q, left_n;
  logic [LW-1:0]     lane_q, lane_n;
  logic [DATA_W-1:0] word_q, word_n;
  logic [NB-1:0]     be_q, be_n;
  logic              wv_q, wv_n;
  logic              big_q, big_n;
  logic              rev_q, rev_n;
  logic              take;
  logic              en;
  logic [LW-1:0]     pos;
  logic [7:0]        placed;

  assign ready_o = !wv_q && (left_q != '0);
  assign take    = valid_i && ready_o;
  assign pos     = big_q ? LW'(NB - 1) - lane_q : lane_q;
  assign placed  = rev_q ? flip_bits(byte_i) : byte_i;
  assign en      = load_i || take || consume_i;

  always_comb begin
    left_n = left_q;
    lane_n = lane_q;
    word_n = word_q;
    be_n   = be_q;
    wv_n   = wv_q;
    big_n  = big_q;
    rev_n  = rev_q;
    if (load_i) begin
      left_n = count_i;
      lane_n = '0;
      word_n = '0;
      be_n   = '0;
      wv_n   = 1'b0;
      big_n  = big_i;
      rev_n  = rev_i;
    end else if (consume_i) begin
      word_n = '0;
      be_n   = '0;
      wv_n   = 1'b0;
    end else if (take) begin
      for (int g = 0; g < NB; g++) begin
        if (pos == LW'(g)) begin
          word_n[8*g +: 8] = placed;
          be_n[g]          = 1'b1;
        end
      end
      left_n = left_q - 1'b1;
      if ((lane_q == LW'(NB - 1)) || (left_q == CNT_W'(1))) begin
        wv_n   = 1'b1;
        lane_n = '0;
      end else begin
        lane_n = lane_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      lane_q <= '0;
      word_q <= '0;
      be_q   <= '0;
      wv_q   <= 1'b0;
      big_q  <= 1'b0;
      rev_q  <= 1'b0;
    end else if (en) begin
      left_q <= left_n;
      lane_q <= lane_n;
      word_q <= word_n;
      be_q   <= be_n;
      wv_q   <= wv_n;
      big_q  <= big_n;
      rev_q  <= rev_n;
    end
  end

  assign word_o       = word_q;
  assign be_o         = be_q;
  assign word_valid_o = wv_q;

endmodule

// File: rtl/dma_watchdog.sv
module dma_watchdog #(
  parameter int LIMIT = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  output logic expired_o
);
  localparam int WW = $clog2(LIMIT + 1);

  logic [WW-1:0] cnt_q, cnt_n;

  assign expired_o = arm_i && (cnt_q == WW'(LIMIT - 1));

  always_comb begin
    if (arm_i) cnt_n = cnt_q + 1'b1;
    else       cnt_n = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

endmodule

// File: rtl/dma_burst_ctrl.sv
module dma_burst_ctrl #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 16,
  parameter int BURST_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              gnt_i,
  input  logic              ack_i,
  input  logic              word_valid_i,
  input  logic              expired_i,
  output logic              load_o,
  output logic              consume_o,
  output logic              arm_o,
  output logic              req_o,
  output logic              wr_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              start_ack_o,
  output logic              done_o,
  output logic              timeout_o
);
  import dma_wr_pkg::*;

  localparam int NB  = DATA_W / 8;
  localparam int LW  = $clog2(NB);
  localparam int BCW = $clog2(BURST_LEN + 1);

  dma_state_e        state_q, state_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [CNT_W-1:0]  words_q, words_n;
  logic [BCW-1:0]    bcnt_q, bcnt_n;
  logic              first_q, first_n;
  logic              err_q, err_n;
  logic              accept;
  logic [CNT_W:0]    round_up;

  assign round_up    = {1'b0, count_i} + (CNT_W+1)'(NB - 1);
  assign wr_o        = (state_q == ST_XFER) && gnt_i && word_valid_i;
  assign accept      = wr_o && ack_i;
  assign consume_o   = accept;
  assign load_o      = (state_q == ST_IDLE) && start_i;
  assign req_o       = (state_q == ST_REQ) || (state_q == ST_XFER);
  assign start_ack_o = (state_q == ST_REQ) && gnt_i && first_q;
  assign arm_o       = ((state_q == ST_REQ) && !gnt_i) || (wr_o && !ack_i);
  assign done_o      = (state_q == ST_FIN);
  assign timeout_o   = (state_q == ST_FIN) && err_q;
  assign addr_o      = addr_q;

  always_comb begin
    state_n = state_q;
    addr_n  = addr_q;
    words_n = words_q;
    bcnt_n  = bcnt_q;
    first_n = first_q;
    err_n   = err_q;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          addr_n  = addr_i;
          words_n = CNT_W'(round_up >> LW);
          err_n   = 1'b0;
          first_n = 1'b1;
          state_n = (count_i == '0) ? ST_FIN : ST_REQ;
        end
      end
      ST_REQ: begin
        if (expired_i) begin
          err_n   = 1'b1;
          state_n = ST_FIN;
        end else if (gnt_i) begin
          bcnt_n  = '0;
          first_n = 1'b0;
          state_n = ST_XFER;
        end
      end
      ST_XFER: begin
        if (expired_i) begin
          err_n   = 1'b1;
          state_n = ST_FIN;
        end else if (accept) begin
          addr_n  = addr_q + ADDR_W'(NB);
          words_n = words_q - 1'b1;
          bcnt_n  = bcnt_q + 1'b1;
          if ((words_q == CNT_W'(1)) || (bcnt_q == BCW'(BURST_LEN - 1)))
            state_n = ST_REL;
        end
      end
      ST_REL:  state_n = (words_q == '0) ? ST_FIN : ST_REQ;
      ST_FIN:  state_n = ST_IDLE;
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      words_q <= '0;
      bcnt_q  <= '0;
      first_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      addr_q  <= addr_n;
      words_q <= words_n;
      bcnt_q  <= bcnt_n;
      first_q <= first_n;
      err_q   <= err_n;
    end
  end

endmodule

// File: rtl/dma_write_engine.sv
module dma_write_engine #(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 16,
  parameter int BURST_LEN  = 4,
  parameter int WDOG_LIMIT = 256
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [ADDR_W-1:0]   start_addr_i,
  input  logic [CNT_W-1:0]    byte_count_i,
  input  logic                cfg_big_endian_i,
  input  logic                cfg_bit_rev_i,
  output logic                start_ack_o,
  output logic                done_o,
  output logic                timeout_o,
  input  logic [7:0]          fifo_data_i,
  input  logic                fifo_valid_i,
  output logic                fifo_ready_o,
  output logic                bus_req_o,
  input  logic                bus_gnt_i,
  output logic [ADDR_W-1:0]   bus_addr_o,
  output logic [DATA_W-1:0]   bus_wdata_o,
  output logic [DATA_W/8-1:0] bus_be_o,
  output logic                bus_wr_o,
  input  logic                bus_ack_i
);

  logic load;
  logic consume;
  logic arm;
  logic expired;
  logic word_valid;

  dma_byte_packer #(
    .DATA_W(DATA_W),
    .CNT_W (CNT_W)
  ) u_pack (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load),
    .count_i     (byte_count_i),
    .big_i       (cfg_big_endian_i),
    .rev_i       (cfg_bit_rev_i),
    .byte_i      (fifo_data_i),
    .valid_i     (fifo_valid_i),
    .ready_o     (fifo_ready_o),
    .word_o      (bus_wdata_o),
    .be_o        (bus_be_o),
    .word_valid_o(word_valid),
    .consume_i   (consume)
  );

  dma_burst_ctrl #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .CNT_W    (CNT_W),
    .BURST_LEN(BURST_LEN)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .addr_i      (start_addr_i),
    .count_i     (byte_count_i),
    .gnt_i       (bus_gnt_i),
    .ack_i       (bus_ack_i),
    .word_valid_i(word_valid),
    .expired_i   (expired),
    .load_o      (load),
    .consume_o   (consume),
    .arm_o       (arm),
    .req_o       (bus_req_o),
    .wr_o        (bus_wr_o),
    .addr_o      (bus_addr_o),
    .start_ack_o (start_ack_o),
    .done_o      (done_o),
    .timeout_o   (timeout_o)
  );

  dma_watchdog #(
    .LIMIT(WDOG_LIMIT)
  ) u_wdog (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm_i    (arm),
    .expired_o(expired)
  );

endmodule

// File: rtl/dma_write_engine_chk.sv
module dma_write_engine_chk #(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 32,
  parameter int BURST_LEN = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start_ack_o,
  input logic                done_o,
  input logic                timeout_o,
  input logic                bus_req_o,
  input logic                bus_gnt_i,
  input logic [ADDR_W-1:0]   bus_addr_o,
  input logic [DATA_W-1:0]   bus_wdata_o,
  input logic [DATA_W/8-1:0] bus_be_o,
  input logic                bus_wr_o,
  input logic                bus_ack_i
);
  localparam int NB = DATA_W / 8;

  logic [15:0] burst_words;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     burst_words <= '0;
    else if (!bus_req_o)            burst_words <= '0;
    else if (bus_wr_o && bus_ack_i) burst_words <= burst_words + 1'b1;
  end

  a_r3_write_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr_o |-> (bus_req_o && bus_gnt_i));

  a_r3_burst_bound: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_o |-> (burst_words <= 16'(BURST_LEN)));

  a_r2_ack_on_grant: assert property (@(posedge clk) disable iff (!rst_n)
    start_ack_o |-> (bus_req_o && bus_gnt_i));

  a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_o && bus_ack_i) |=> (bus_addr_o == ($past(bus_addr_o) + ADDR_W'(NB))));

  a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_o && !bus_ack_i) |=> ($stable(bus_addr_o) && $stable(bus_wdata_o) && $stable(bus_be_o)));

  a_r7_enables_present: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr_o |-> (bus_be_o != '0));

  a_r9_timeout_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> done_o);

  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r11_done_bus_free: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!bus_req_o && !bus_wr_o));

endmodule

bind dma_write_engine dma_write_engine_chk #(
  .DATA_W   (DATA_W),
  .ADDR_W   (ADDR_W),
  .BURST_LEN(BURST_LEN)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_ack_o(start_ack_o),
  .done_o     (done_o),
  .timeout_o  (timeout_o),
  .bus_req_o  (bus_req_o),
  .bus_gnt_i  (bus_gnt_i),
  .bus_addr_o (bus_addr_o),
  .bus_wdata_o(bus_wdata_o),
  .bus_be_o   (bus_be_o),
  .bus_wr_o   (bus_wr_o),
  .bus_ack_i  (bus_ack_i)
);

// File: tb/dma_write_engine_test.sv
`timescale 1ns/1ps
module dma_write_engine_test;
  localparam int DW = 32;
  localparam int AW = 32;
  localparam int CW = 16;
  localparam int BL = 4;
  localparam int WD = 16;
  localparam int NB = DW / 8;

  logic          clk;
  logic          rst_n;
  logic          start_i;
  logic [AW-1:0] start_addr_i;
  logic [CW-1:0] byte_count_i;
  logic          cfg_big_endian_i;
  logic          cfg_bit_rev_i;
  logic          start_ack_o;
  logic          done_o;
  logic          timeout_o;
  logic [7:0]    fifo_data_i;
  logic          fifo_valid_i;
  logic          fifo_ready_o;
  logic          bus_req_o;
  logic          bus_gnt_i;
  logic [AW-1:0] bus_addr_o;
  logic [DW-1:0] bus_wdata_o;
  logic [NB-1:0] bus_be_o;
  logic          bus_wr_o;
  logic          bus_ack_i;

  dma_write_engine #(
    .DATA_W(DW), .ADDR_W(AW), .CNT_W(CW), .BURST_LEN(BL), .WDOG_LIMIT(WD)
  ) uut (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // bench-side stream, bus slave and monitor state
  logic [7:0]    src [0:255];
  int            feed_len = 0;
  int            ptr = 0;
  int            mode = 0;          // 0 normal, 1 never grant, 2 never accept
  int            gdly = 0;
  int            stall = 0;
  int            cyc = 0;
  int            grants = 0;
  int            bwords = 0;
  int            burst_over = 0;
  int            acks = 0;
  int            req_seen = 0;
  int            done_cnt = 0;
  int            done_cyc = 0;
  bit            done_to = 1'b0;
  int            hold_err = 0;
  bit            prev_stall = 1'b0;
  logic [AW-1:0] prev_addr;
  logic [DW-1:0] prev_data;
  logic [NB-1:0] prev_be;
  int            rec_n = 0;
  logic [AW-1:0] rec_addr [0:127];
  logic [DW-1:0] rec_data [0:127];
  logic [NB-1:0] rec_be   [0:127];

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      bus_gnt_i = 1'b0; bus_ack_i = 1'b0; fifo_valid_i = 1'b0; fifo_data_i = '0;
    end else begin
      if (!bus_req_o) begin
        bus_gnt_i = 1'b0;
        gdly = $urandom_range(0, 4);
      end else if (!bus_gnt_i && mode != 1) begin
        if (gdly == 0) begin
          bus_gnt_i = 1'b1;
          grants++;
          bwords = 0;
        end else gdly--;
      end
      #1;
      if (prev_stall && (bus_addr_o !== prev_addr || bus_wdata_o !== prev_data || bus_be_o !== prev_be))
        hold_err++;
      if (start_ack_o) acks++;
      if (bus_req_o) req_seen++;
      if (done_o) begin
        done_cnt++; done_cyc = cyc; done_to = timeout_o;
      end
      if (bus_wr_o && mode != 2) begin
        bus_ack_i = ($urandom_range(0, 9) < 7) || (stall >= 2);
      end else bus_ack_i = 1'b0;
      if (bus_wr_o && bus_ack_i) begin
        if (rec_n < 128) begin
          rec_addr[rec_n] = bus_addr_o; rec_data[rec_n] = bus_wdata_o; rec_be[rec_n] = bus_be_o;
        end
        rec_n++; bwords++; stall = 0;
        if (bwords > BL) burst_over++;
      end else if (bus_wr_o) stall++;
      prev_stall = bus_wr_o && !bus_ack_i;
      prev_addr = bus_addr_o; prev_data = bus_wdata_o; prev_be = bus_be_o;
      if (ptr < feed_len) begin
        fifo_valid_i = ($urandom_range(0, 9) < 8);
        fifo_data_i  = src[ptr];
        if (fifo_valid_i && fifo_ready_o) ptr++;
      end else begin
        fifo_valid_i = 1'b0;
      end
    end
  end

  function automatic logic [7:0] rbits(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

  function automatic logic [DW-1:0] exp_data(input int w, input int cnt, input bit big, input bit rev);
    logic [DW-1:0] d = '0;
    for (int k = 0; k < NB; k++) begin
      int idx  = w * NB + k;
      int lane = big ? NB - 1 - k : k;
      if (idx < cnt) d[8*lane +: 8] = rev ? rbits(src[idx]) : src[idx];
    end
    return d;
  endfunction

  function automatic logic [NB-1:0] exp_be(input int w, input int cnt, input bit big);
    logic [NB-1:0] e = '0;
    for (int k = 0; k < NB; k++) begin
      int lane = big ? NB - 1 - k : k;
      if (w * NB + k < cnt) e[lane] = 1'b1;
    end
    return e;
  endfunction

  task automatic run(input logic [AW-1:0] addr, input int cnt, input bit big, input bit rev, input int m);
    int d0, sc, nw, bad_a, bad_d, bad_b;
    for (int i = 0; i < 256; i++) src[i] = 8'($urandom);
    @(negedge clk);
    #2;
    mode = m; ptr = 0; feed_len = cnt; rec_n = 0; grants = 0; acks = 0;
    req_seen = 0; burst_over = 0; hold_err = 0; d0 = done_cnt;
    start_addr_i = addr; byte_count_i = CW'(cnt);
    cfg_big_endian_i = big; cfg_bit_rev_i = rev;
    start_i = 1'b1;
    @(negedge clk);
    sc = cyc - 1;
    #2;
    start_i = 1'b0;
    for (int t = 0; t < 3000 && done_cnt == d0; t++) begin
      @(negedge clk); #2;
    end
    repeat (2) begin @(negedge clk); #2; end
    chk(done_cnt == d0 + 1, "R11", "single done pulse", done_cnt - d0, 1);
    chk(!bus_req_o, "R11", "request low after done", bus_req_o, 0);
    if (cnt == 0) begin
      chk(req_seen == 0 && rec_n == 0, "R10", "zero count touched bus", req_seen + rec_n, 0);
      chk(!done_to && (done_cyc - sc) <= 2, "R10", "zero count done delay", done_cyc - sc, 1);
    end else if (m == 1) begin
      chk(done_to, "R9", "timeout without grant", done_to, 1);
      chk((done_cyc - sc) >= WD && (done_cyc - sc) <= WD + 2, "R9", "watchdog delay", done_cyc - sc, WD + 1);
      chk(rec_n == 0 && acks == 0, "R9", "no writes without grant", rec_n, 0);
    end else if (m == 2) begin
      chk(done_to, "R9", "timeout on stalled write", done_to, 1);
      chk(rec_n == 0, "R9", "no accepted writes", rec_n, 0);
      chk(hold_err == 0, "R8", "stalled write changed", hold_err, 0);
    end else begin
      nw = (cnt + NB - 1) / NB;
      bad_a = 0; bad_d = 0; bad_b = 0;
      for (int w = 0; w < nw && w < rec_n && w < 128; w++) begin
        if (rec_addr[w] !== addr + AW'(w * NB)) bad_a++;
        if (rec_data[w] !== exp_data(w, cnt, big, rev)) begin
          bad_d++;
          if (bad_d == 1)
            chk(0, rev ? "R6" : "R5", "word data", rec_data[w], exp_data(w, cnt, big, rev));
        end
        if (rec_be[w] !== exp_be(w, cnt, big)) begin
          bad_b++;
          if (bad_b == 1) chk(0, "R7", "byte enables", rec_be[w], exp_be(w, cnt, big));
        end
      end
      chk(!done_to, "R11", "timeout flag on good transfer", done_to, 0);
      chk(rec_n == nw, "R4", "word count", rec_n, nw);
      chk(bad_a == 0, "R4", "address sequence errors", bad_a, 0);
      chk(bad_d == 0, big ? "R5" : "R6", "data words wrong", bad_d, 0);
      chk(bad_b == 0, "R7", "enable words wrong", bad_b, 0);
      chk(acks == 1, "R2", "start acknowledge pulses", acks, 1);
      chk(grants == (nw + BL - 1) / BL, "R3", "grants per transfer", grants, (nw + BL - 1) / BL);
      chk(burst_over == 0, "R3", "words beyond burst", burst_over, 0);
      chk(hold_err == 0, "R8", "data changed during stall", hold_err, 0);
    end
    mode = 0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: run hung, actual %0d expected 0", 1);
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    rst_n = 1'b0; start_i = 1'b0; start_addr_i = '0; byte_count_i = '0;
    cfg_big_endian_i = 1'b0; cfg_bit_rev_i = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;
    chk(!bus_req_o && !bus_wr_o && !fifo_ready_o && !start_ack_o && !done_o,
        "R1", "outputs after reset",
        {bus_req_o, bus_wr_o, fifo_ready_o, start_ack_o, done_o}, 0);

    // directed corners: R5 R6 R7 boundaries
    run(32'h0000_1000, 1,          0, 0, 0);
    run(32'h0000_2000, NB,         1, 0, 0);
    run(32'h0000_3000, NB*BL - 1,  0, 1, 0);
    run(32'h0000_4000, NB*BL,      1, 1, 0);
    run(32'h0000_5000, NB*BL + 1,  0, 0, 0);
    run(32'h0000_6000, 0,          0, 0, 0);   // R10
    run(32'h0000_7000, 8,          0, 0, 1);   // R9 no grant
    run(32'h0000_8000, 8,          1, 0, 2);   // R9 no acceptance
    run(32'h0000_9000, 3*NB*BL+3,  1, 1, 0);

    for (int n = 0; n < 24; n++) begin
      run(AW'($urandom_range(0, 4095)) << 2, $urandom_range(1, 100),
          1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 0);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule